// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This block sits beside a five-stage in-order pipeline. It watches two fault sources: an arithmetic overflow flag raised by the execute stage, and an undefined-opcode flag raised by the decode stage. When it accepts a fault, in that same cycle it flushes the faulting instruction and every younger instruction. It also stops the faulting instruction from writing its destination register and steers fetch to a fixed handler entry point. On the next clock edge it saves the faulting instruction's program counter and a one-bit reason code.

Instructions older than the faulting one are left alone and complete normally. Flushing zeroes the control fields of the affected pipeline registers, which is the same path a mispredicted branch uses. An overflow in execute wins over an undefined opcode in decode because the instruction in execute is older. The redirect lasts one cycle. In the cycle after an accepted fault the unit ignores both flags, since those stages then hold only bubbles.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While reset is held and after it is released, `epc` and `cause` read zero, and every flush, kill and redirect output is low until a fault is accepted.
- R2: An accepted execute-stage overflow loads `epc` with `ex_pc` and sets `cause` to 1 (overflow); both are visible from the clock edge that ends the fault cycle.
- R3: An accepted decode-stage undefined opcode with no overflow in the same cycle loads `epc` with `id_pc` and sets `cause` to 0 (undefined opcode).
- R4: When both flags are high in one cycle, the overflow is taken: `epc` gets `ex_pc`, `cause` becomes 1, and the overflow flush set is driven.
- R5: In an overflow fault cycle, `flush_ifid`, `flush_idex`, `flush_exmem` and `kill_regwr` are all high in that same cycle.
- R6: In an undefined-opcode fault cycle, `flush_ifid` and `flush_idex` are high while `flush_exmem` and `kill_regwr` stay low, so the older instruction in execute completes.
- R7: `redirect_valid` is high exactly in a fault cycle, with `redirect_pc` equal to 0x80000180; otherwise `redirect_pc` reads zero.
- R8: A fault is never accepted in two consecutive cycles. In the cycle after an accepted fault, flags are ignored: no redirect, no flush, no kill, and `epc` and `cause` stay unchanged.
- R9: `epc` and `cause` change only on the edge that ends an accepted fault cycle.
- R10: With both flags low, all flush, kill and redirect outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_pc | input | 32 | Program counter of the instruction in decode |
| ex_pc | input | 32 | Program counter of the instruction in execute |
| ex_overflow | input | 1 | Execute-stage arithmetic overflow |
| id_undef | input | 1 | Decode-stage undefined opcode |
| epc | output | 32 | Saved program counter of the last faulting instruction |
| cause | output | 1 | Last fault reason: 1 overflow, 0 undefined opcode |
| flush_ifid | output | 1 | Zero the fetch/decode pipeline register |
| flush_idex | output | 1 | Zero the decode/execute control fields |
| flush_exmem | output | 1 | Zero the execute/memory control fields |
| kill_regwr | output | 1 | Suppress the register write of the instruction in execute |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Handler address while redirecting, else zero |

## Verification
The only state in this block is the suppression bit and the two saved registers. If the suppression bit were wrong, a held flag would show up at the ports as a redirect on two consecutive cycles, or as an accepted fault missing in the cycle after a masked one. Either error appears within one cycle. A saved-register fault shows up on `epc` or `cause` right after the edge that ends the fault cycle, or as drift on an edge with no fault. A priority fault shows up in the same cycle as a wrong `flush_exmem` or `kill_regwr`.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned PC_W = 32;
  localparam logic [PC_W-1:0] HANDLER_VEC = 32'h8000_0180;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned W = PC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ex_overflow,
  input  logic         id_undef,
  input  logic         masked,
  input  logic [W-1:0] id_pc,
  input  logic [W-1:0] ex_pc,
  output logic         take,
  output logic         take_ex,
  output logic [W-1:0] fault_pc,
  output exc_cause_e   fault_cause
);
  logic any_flag;

  // execute holds the older instruction, so it wins
  always_comb begin
    any_flag    = ex_overflow | id_undef;
    take        = rst_n & any_flag & ~masked;
    take_ex     = take & ex_overflow;
    fault_pc    = ex_overflow ? ex_pc : id_pc;
    fault_cause = ex_overflow ? CAUSE_OVF : CAUSE_UNDEF;
  end

  // R4: a simultaneous pair resolves to the execute source
  a_r4_ovf_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ex_overflow && id_undef) |-> (take_ex && fault_pc == ex_pc));

  // R8: a masked cycle accepts nothing
  a_r8_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !take);
endmodule

// File: rtl/exc_record.sv
module exc_record
  import exc_pkg::*;
#(
  parameter int unsigned W = PC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] fault_pc,
  input  exc_cause_e   fault_cause,
  output logic [W-1:0] epc_q,
  output exc_cause_e   cause_q,
  output logic         masked_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q    <= '0;
      cause_q  <= CAUSE_UNDEF;
      masked_q <= 1'b0;
    end else begin
      masked_q <= take;
      if (take) begin
        epc_q   <= fault_pc;
        cause_q <= fault_cause;
      end
    end
  end

  // R9: saved state moves only after an accepted fault
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(epc_q) && $stable(cause_q)));

  // R2: captured address matches the one presented in the fault cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(fault_pc)));
endmodule

// File: rtl/exc_flush.sv
module exc_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_ex,
  output logic flush_ifid,
  output logic flush_idex,
  output logic flush_exmem,
  output logic kill_regwr
);
  always_comb begin
    flush_ifid  = take;
    flush_idex  = take;
    flush_exmem = take_ex;
    kill_regwr  = take_ex;
  end

  // R5: a killed write always comes with a full younger flush
  a_r5_kill_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
    kill_regwr |-> (flush_ifid && flush_idex && flush_exmem));

  // R6: execute is flushed only together with the earlier stages
  a_r6_exmem_implies_front: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |-> flush_idex);
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] id_pc,
  input  logic [31:0] ex_pc,
  input  logic        ex_overflow,
  input  logic        id_undef,
  output logic [31:0] epc,
  output logic        cause,
  output logic        flush_ifid,
  output logic        flush_idex,
  output logic        flush_exmem,
  output logic        kill_regwr,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc
);
  logic            take;
  logic            take_ex;
  logic            masked;
  logic [PC_W-1:0] fault_pc;
  exc_cause_e      fault_cause;
  exc_cause_e      cause_q;

  exc_arbiter #(.W(PC_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_overflow (ex_overflow),
    .id_undef    (id_undef),
    .masked      (masked),
    .id_pc       (id_pc),
    .ex_pc       (ex_pc),
    .take        (take),
    .take_ex     (take_ex),
    .fault_pc    (fault_pc),
    .fault_cause (fault_cause)
  );

  exc_record #(.W(PC_W)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .fault_pc    (fault_pc),
    .fault_cause (fault_cause),
    .epc_q       (epc),
    .cause_q     (cause_q),
    .masked_q    (masked)
  );

  exc_flush u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .take_ex     (take_ex),
    .flush_ifid  (flush_ifid),
    .flush_idex  (flush_idex),
    .flush_exmem (flush_exmem),
    .kill_regwr  (kill_regwr)
  );

  always_comb begin
    cause          = cause_q;
    redirect_valid = take;
    redirect_pc    = take ? HANDLER_VEC : '0;
  end

  // R8: the redirect never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R2: an overflow fault records the overflow code
  a_r2_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && ex_overflow) |=> (cause == 1'b1 && epc == $past(ex_pc)));

  // R10: quiet flags produce no control activity
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_overflow && !id_undef) |-> !(redirect_valid || flush_ifid || kill_regwr));

  // R7: redirect target is the handler vector
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc == 32'h8000_0180));
endmodule

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_pc = '0;
  logic [31:0] ex_pc = '0;
  logic        ex_overflow = 1'b0;
  logic        id_undef = 1'b0;
  logic [31:0] epc;
  logic        cause;
  logic        flush_ifid, flush_idex, flush_exmem, kill_regwr;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        m_hold = 1'b0;
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  logic [31:0] q_epc[$];
  logic        q_cause[$];
  string       q_req[$];

  always #5 clk = ~clk;

  exc_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .id_pc(id_pc), .ex_pc(ex_pc),
    .ex_overflow(ex_overflow), .id_undef(id_undef),
    .epc(epc), .cause(cause), .flush_ifid(flush_ifid),
    .flush_idex(flush_idex), .flush_exmem(flush_exmem),
    .kill_regwr(kill_regwr), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, checks same-cycle controls,
  // and queues the saved state expected after the next edge
  task automatic step(input logic ovf, input logic und,
                      input logic [31:0] ipc, input logic [31:0] xpc,
                      input string req);
    logic tk, tk_ex;
    @(negedge clk);
    ex_overflow = ovf; id_undef = und; id_pc = ipc; ex_pc = xpc;
    tk    = (ovf | und) & ~m_hold;
    tk_ex = tk & ovf;
    #1;
    check(req, "redirect_valid", {31'b0, redirect_valid}, {31'b0, tk});
    check(req, "redirect_pc", redirect_pc, tk ? VEC : 32'h0);
    check(req, "flush_ifid", {31'b0, flush_ifid}, {31'b0, tk});
    check(req, "flush_idex", {31'b0, flush_idex}, {31'b0, tk});
    check(req, "flush_exmem", {31'b0, flush_exmem}, {31'b0, tk_ex});
    check(req, "kill_regwr", {31'b0, kill_regwr}, {31'b0, tk_ex});
    if (tk) begin
      m_epc   = ovf ? xpc : ipc;
      m_cause = ovf;
    end
    m_hold = tk;
    q_epc.push_back(m_epc);
    q_cause.push_back(m_cause);
    q_req.push_back(req);
  endtask

  // monitor: compares saved state after each edge
  always @(posedge clk) begin
    #2;
    if (q_epc.size() > 0) begin
      logic [31:0] e;
      logic        c;
      string       r;
      e = q_epc.pop_front();
      c = q_cause.pop_front();
      r = q_req.pop_front();
      check(r, "epc", epc, e);
      check(r, "cause", {31'b0, cause}, {31'b0, c});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    check("R1", "epc in reset", epc, 32'h0);
    check("R1", "cause in reset", {31'b0, cause}, 32'h0);
    check("R1", "redirect in reset", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 32'h0000_0040, 32'h0000_003C, "R1");
    step(1'b0, 1'b0, 32'h0000_0044, 32'h0000_0040, "R10");
    // R2 and R5: overflow in execute
    step(1'b1, 1'b0, 32'h0000_0048, 32'h0000_0044, "R2");
    step(1'b0, 1'b0, 32'h0000_0100, 32'h0000_00FC, "R9");
    step(1'b1, 1'b0, 32'h0000_0200, 32'h0000_01FC, "R5");
    step(1'b0, 1'b0, 32'h0000_0204, 32'h0000_0200, "R9");
    // R3 and R6: undefined opcode in decode
    step(1'b0, 1'b1, 32'h0000_0300, 32'h0000_02FC, "R3");
    step(1'b0, 1'b0, 32'h0000_0304, 32'h0000_0300, "R10");
    step(1'b0, 1'b1, 32'h0000_0400, 32'h0000_03FC, "R6");
    step(1'b0, 1'b0, 32'h0000_0404, 32'h0000_0400, "R7");
    // R4: both in one cycle
    step(1'b1, 1'b1, 32'h0000_0504, 32'h0000_0500, "R4");
    step(1'b0, 1'b0, 32'h0000_0508, 32'h0000_0504, "R9");
    // R8: flag held high for several cycles
    step(1'b1, 1'b0, 32'h0000_0604, 32'h0000_0600, "R8");
    step(1'b1, 1'b0, 32'h0000_0608, 32'h0000_0604, "R8");
    step(1'b1, 1'b0, 32'h0000_060C, 32'h0000_0608, "R8");
    step(1'b0, 1'b1, 32'h0000_0700, 32'h0000_06FC, "R8");
    step(1'b0, 1'b1, 32'h0000_0704, 32'h0000_0700, "R8");
    step(1'b0, 1'b0, 32'h0000_0708, 32'h0000_0704, "R10");
    // R7: redirect follows every accepted fault
    step(1'b1, 1'b0, 32'hFFFF_FFF8, 32'hFFFF_FFF4, "R7");
    step(1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, "R9");
    step(1'b0, 1'b0, 32'h0000_0004, 32'h0000_0000, "R9");
    @(negedge clk);
    ex_overflow = 1'b0; id_undef = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R9", "queue drained", q_epc.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule